// File: doc/BRIEF.md
# Composite Sync and Blanking Generator

This block turns raster position into the timing pulses a monochrome camera needs around its sensor and encoder. A separate timing counter supplies the tick position inside the current half-line, which half of the line is running, the line number within the field and the field parity. From these the block derives four registered pulses: an active-low composite sync, an active-high composite blanking, an active-high horizontal blanking that tells the sensor drive when to halt horizontal register transfer, and an active-high optical-black clamp pulse.

Two broadcast standards are supported through one mode pin: the 525-line style (EIA, RS-170 sync) and the 625-line style (CCIR). The mode picks the half-line length, the pulse widths and the number of vertically blanked lines. Around the vertical interval, composite sync is built from three sections of six half-lines each: equalizing pulses, serrated vertical sync, then equalizing pulses again. The interval begins half a line later in the even field than in the odd field, which yields interlace. The clamp pulse either runs on every line or is held low on the vertically blanked lines, selected by a second mode pin.

All edge positions are parameters counted in prescaled ticks. Outputs are registered and change only in cycles where the tick enable is high. Every pin is plain control: no data stream crosses the block's boundary, so there is no valid/ready interface and no back-pressure.

Top module: `csync_gen_top`

## Requirements
- R1: While `rst_n` is low, `csync_n` is 1 and `cblank`, `hblank` and `clamp` are 0.
- R2: Outputs take the value decoded from the inputs present in a cycle with `tick_en` high, one clock later. In cycles with `tick_en` low they hold.
- R3: On a half-line outside the vertical interval, `csync_n` is 0 when `half_sel` is 0 and `hpos` is below the horizontal sync width. It is 1 for the rest of that half-line and for the whole of the second half (`half_sel` = 1).
- R4: Half-lines 0–5 and 12–17 of the vertical interval are equalizing half-lines: `csync_n` is 0 only while `hpos` is below the equalizing width.
- R5: Half-lines 6–11 of the vertical interval are serration half-lines: `csync_n` is 0 while `hpos` is below (half-line length − serration width) and 1 above that.
- R6: The half-line index is 2·`line_idx` + `half_sel`. The vertical interval starts at index 0 when `field_odd` is 1 and at index 1 when `field_odd` is 0. A line-0 first half in the even field is a normal half-line.
- R7: `cblank` is 1 on every tick of lines 0 to VB−1, where VB is 20 in EIA mode and 25 in CCIR mode. On other lines it is 1 only in the first half while `hpos` is below the composite blanking width.
- R8: `hblank` is 1 only in the first half of a line while `hpos` is below the horizontal blanking width.
- R9: The clamp window covers the first half of a line with CLAMP_START ≤ `hpos` < CLAMP_START + CLAMP_W. With `clamp_cont` = 1, `clamp` is 1 exactly in that window on every line, including vertically blanked lines.
- R10: With `clamp_cont` = 0, `clamp` stays 0 on lines 0 to VB−1. On other lines it follows the window of R9.
- R11: `sys_ccir` = 0 selects the EIA set of widths, half-line length and VB. `sys_ccir` = 1 selects the CCIR set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_en | input | 1 | Prescaled tick enable; outputs update only in these cycles |
| sys_ccir | input | 1 | 0: EIA timing, 1: CCIR timing |
| clamp_cont | input | 1 | 1: clamp on every line, 0: clamp suppressed during vertical blanking |
| field_odd | input | 1 | 1: odd field, 0: even field (interval shifted by one half-line) |
| line_idx | input | LINE_W | Line number within the field, 0 at field start |
| half_sel | input | 1 | 0: first half of the line, 1: second half |
| hpos | input | POS_W | Tick position inside the current half-line |
| csync_n | output | 1 | Composite sync, active low |
| cblank | output | 1 | Composite blanking, active high |
| hblank | output | 1 | Horizontal transfer stop, active high |
| clamp | output | 1 | Optical-black clamp pulse, active high |

## Verification
The bench builds the block with short half-lines: 40 ticks for EIA and 48 for CCIR. Pulse widths are 3/4 for equalizing, 8/9 for sync, 6/7 for serration, 20/22 for composite blanking and 16/18 for horizontal blanking, with a clamp window of ticks 10–13. The two modes differ in every width, so each boundary tick can be reached directly and a wrong selection shows up. The line-count thresholds stay at 20 and 25, and the vertical section sizes stay at six half-lines. That keeps the field-parity offset, the section edges at half-lines 6, 12 and 18, and the last blanked line all in reach with the same vectors.

// File: rtl/csync_gen_pkg.sv
package csync_gen_pkg;

  // Common width of every tick-count timing field.
  localparam int unsigned TW = 16;

  // Kind of half-line the raster is currently in.
  typedef enum logic [1:0] {
    ZN_NORMAL = 2'd0,
    ZN_EQUAL  = 2'd1,
    ZN_SERR   = 2'd2
  } hl_zone_e;

  // Per-standard timing set, all counts in prescaled ticks.
  typedef struct packed {
    logic [TW-1:0] half_len;
    logic [TW-1:0] eq_w;
    logic [TW-1:0] hs_w;
    logic [TW-1:0] serr_w;
    logic [TW-1:0] cb_w;
    logic [TW-1:0] hb_w;
    logic [TW-1:0] vb_lines;
  } std_timing_t;

endpackage

// File: rtl/std_timing_sel.sv
module std_timing_sel
  import csync_gen_pkg::*;
#(
  parameter int unsigned HALF_EIA   = 303,
  parameter int unsigned HALF_CCIR  = 309,
  parameter int unsigned EQ_EIA     = 15,
  parameter int unsigned EQ_CCIR    = 15,
  parameter int unsigned HS_EIA     = 45,
  parameter int unsigned HS_CCIR    = 45,
  parameter int unsigned SERR_EIA   = 45,
  parameter int unsigned SERR_CCIR  = 45,
  parameter int unsigned CB_EIA     = 105,
  parameter int unsigned CB_CCIR    = 117,
  parameter int unsigned HB_EIA     = 82,
  parameter int unsigned HB_CCIR    = 94,
  parameter int unsigned VB_EIA     = 20,
  parameter int unsigned VB_CCIR    = 25
) (
  input  logic        sys_ccir,
  output std_timing_t tim
);

  localparam int unsigned NSTD = 2;

  std_timing_t set_q [NSTD];

  // One timing set per standard, indexed by the mode pin.
  for (genvar s = 0; s < NSTD; s++) begin : g_std
    if (s == 0) begin : g_eia
      assign set_q[s] = '{half_len: TW'(HALF_EIA),  eq_w: TW'(EQ_EIA),
                          hs_w:     TW'(HS_EIA),    serr_w: TW'(SERR_EIA),
                          cb_w:     TW'(CB_EIA),    hb_w: TW'(HB_EIA),
                          vb_lines: TW'(VB_EIA)};
    end else begin : g_ccir
      assign set_q[s] = '{half_len: TW'(HALF_CCIR), eq_w: TW'(EQ_CCIR),
                          hs_w:     TW'(HS_CCIR),   serr_w: TW'(SERR_CCIR),
                          cb_w:     TW'(CB_CCIR),   hb_w: TW'(HB_CCIR),
                          vb_lines: TW'(VB_CCIR)};
    end
  end

  assign tim = set_q[sys_ccir];

endmodule

// File: rtl/halfline_zone_decode.sv
module halfline_zone_decode
  import csync_gen_pkg::*;
#(
  parameter int unsigned LINE_W  = 10,
  parameter int unsigned SECT_HL = 6
) (
  input  logic              field_odd,
  input  logic [LINE_W-1:0] line_idx,
  input  logic              half_sel,
  input  logic [TW-1:0]     vb_lines,
  output hl_zone_e          zone,
  output logic              vblank_line
);

  localparam int unsigned HLW      = LINE_W + 1;
  localparam int unsigned SERR_BEG = SECT_HL;
  localparam int unsigned POST_BEG = 2 * SECT_HL;
  localparam int unsigned VINT_END = 3 * SECT_HL;

  logic [HLW-1:0] hl_idx;
  logic [HLW-1:0] hl_rel;

  // Even fields start the vertical interval one half-line later. Index 0
  // of an even field wraps to a large value and so reads as normal.
  assign hl_idx = {line_idx, half_sel};
  assign hl_rel = hl_idx - HLW'(!field_odd);

  always_comb begin
    if (hl_rel < HLW'(SERR_BEG)) begin
      zone = ZN_EQUAL;
    end else if (hl_rel < HLW'(POST_BEG)) begin
      zone = ZN_SERR;
    end else if (hl_rel < HLW'(VINT_END)) begin
      zone = ZN_EQUAL;
    end else begin
      zone = ZN_NORMAL;
    end
  end

  assign vblank_line = (TW'(line_idx) < vb_lines);

endmodule

// File: rtl/csync_shaper.sv
module csync_shaper
  import csync_gen_pkg::*;
(
  input  hl_zone_e      zone,
  input  logic          half_sel,
  input  logic [TW-1:0] pos,
  input  logic [TW-1:0] half_len,
  input  logic [TW-1:0] eq_w,
  input  logic [TW-1:0] hs_w,
  input  logic [TW-1:0] serr_w,
  output logic          sync_low
);

  logic [TW-1:0] serr_rise;

  assign serr_rise = half_len - serr_w;

  always_comb begin
    unique case (zone)
      ZN_EQUAL: sync_low = (pos < eq_w);
      ZN_SERR:  sync_low = (pos < serr_rise);
      default:  sync_low = !half_sel && (pos < hs_w);
    endcase
  end

endmodule

// File: rtl/blank_clamp_gen.sv
module blank_clamp_gen
  import csync_gen_pkg::*;
#(
  parameter int unsigned CLAMP_START = 56,
  parameter int unsigned CLAMP_W     = 20
) (
  input  logic          half_sel,
  input  logic [TW-1:0] pos,
  input  logic          vblank_line,
  input  logic          clamp_cont,
  input  logic [TW-1:0] cb_w,
  input  logic [TW-1:0] hb_w,
  output logic          cblank_d,
  output logic          hblank_d,
  output logic          clamp_d
);

  localparam int unsigned CLAMP_END = CLAMP_START + CLAMP_W;

  logic first_half;
  logic in_clamp_win;

  assign first_half   = !half_sel;
  assign in_clamp_win = first_half && (pos >= TW'(CLAMP_START)) &&
                        (pos < TW'(CLAMP_END));

  assign cblank_d = vblank_line || (first_half && (pos < cb_w));
  assign hblank_d = first_half && (pos < hb_w);
  assign clamp_d  = in_clamp_win && (clamp_cont || !vblank_line);

endmodule

// File: rtl/csync_gen_top.sv
module csync_gen_top
  import csync_gen_pkg::*;
#(
  parameter int unsigned LINE_W      = 10,
  parameter int unsigned POS_W       = 9,
  parameter int unsigned SECT_HL     = 6,
  parameter int unsigned HALF_EIA    = 303,
  parameter int unsigned HALF_CCIR   = 309,
  parameter int unsigned EQ_EIA      = 15,
  parameter int unsigned EQ_CCIR     = 15,
  parameter int unsigned HS_EIA      = 45,
  parameter int unsigned HS_CCIR     = 45,
  parameter int unsigned SERR_EIA    = 45,
  parameter int unsigned SERR_CCIR   = 45,
  parameter int unsigned CB_EIA      = 105,
  parameter int unsigned CB_CCIR     = 117,
  parameter int unsigned HB_EIA      = 82,
  parameter int unsigned HB_CCIR     = 94,
  parameter int unsigned VB_EIA      = 20,
  parameter int unsigned VB_CCIR     = 25,
  parameter int unsigned CLAMP_START = 56,
  parameter int unsigned CLAMP_W     = 20
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_en,
  input  logic              sys_ccir,
  input  logic              clamp_cont,
  input  logic              field_odd,
  input  logic [LINE_W-1:0] line_idx,
  input  logic              half_sel,
  input  logic [POS_W-1:0]  hpos,
  output logic              csync_n,
  output logic              cblank,
  output logic              hblank,
  output logic              clamp
);

  std_timing_t   tim;
  hl_zone_e      zone;
  logic          vblank_line;
  logic [TW-1:0] pos;
  logic          sync_low;
  logic          cblank_d;
  logic          hblank_d;
  logic          clamp_d;

  assign pos = TW'(hpos);

  std_timing_sel #(
    .HALF_EIA (HALF_EIA), .HALF_CCIR (HALF_CCIR),
    .EQ_EIA   (EQ_EIA),   .EQ_CCIR   (EQ_CCIR),
    .HS_EIA   (HS_EIA),   .HS_CCIR   (HS_CCIR),
    .SERR_EIA (SERR_EIA), .SERR_CCIR (SERR_CCIR),
    .CB_EIA   (CB_EIA),   .CB_CCIR   (CB_CCIR),
    .HB_EIA   (HB_EIA),   .HB_CCIR   (HB_CCIR),
    .VB_EIA   (VB_EIA),   .VB_CCIR   (VB_CCIR)
  ) u_tim (
    .sys_ccir (sys_ccir),
    .tim      (tim)
  );

  halfline_zone_decode #(
    .LINE_W  (LINE_W),
    .SECT_HL (SECT_HL)
  ) u_zone (
    .field_odd   (field_odd),
    .line_idx    (line_idx),
    .half_sel    (half_sel),
    .vb_lines    (tim.vb_lines),
    .zone        (zone),
    .vblank_line (vblank_line)
  );

  csync_shaper u_sync (
    .zone     (zone),
    .half_sel (half_sel),
    .pos      (pos),
    .half_len (tim.half_len),
    .eq_w     (tim.eq_w),
    .hs_w     (tim.hs_w),
    .serr_w   (tim.serr_w),
    .sync_low (sync_low)
  );

  blank_clamp_gen #(
    .CLAMP_START (CLAMP_START),
    .CLAMP_W     (CLAMP_W)
  ) u_blank (
    .half_sel    (half_sel),
    .pos         (pos),
    .vblank_line (vblank_line),
    .clamp_cont  (clamp_cont),
    .cb_w        (tim.cb_w),
    .hb_w        (tim.hb_w),
    .cblank_d    (cblank_d),
    .hblank_d    (hblank_d),
    .clamp_d     (clamp_d)
  );

  // Output stage: the only state in the block, advanced on ticks.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      csync_n <= 1'b1;
      cblank  <= 1'b0;
      hblank  <= 1'b0;
      clamp   <= 1'b0;
    end else if (tick_en) begin
      csync_n <= !sync_low;
      cblank  <= cblank_d;
      hblank  <= hblank_d;
      clamp   <= clamp_d;
    end
  end

  // R2: nothing moves between ticks.
  p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !tick_en |=> ($stable(csync_n) && $stable(cblank) &&
                  $stable(hblank) && $stable(clamp)));

  // R7: every sync pulse sits inside composite blanking.
  p_sync_in_blank_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !csync_n |-> cblank);

  // R8: horizontal transfer stop sits inside composite blanking.
  p_hblank_in_blank_r8: assert property (@(posedge clk) disable iff (!rst_n)
    hblank |-> cblank);

  // R10: a gated clamp never fires on a vertically blanked line.
  p_clamp_gated_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_en && !clamp_cont && vblank_line) |=> !clamp);

  // R5: serrated sync only occurs on vertically blanked lines.
  p_serr_in_vblank_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (zone == ZN_SERR) |-> vblank_line);

endmodule

// File: tb/test_csync_gen_top.sv
module test_csync_gen_top;

  localparam int unsigned CLK_PERIOD = 10;
  localparam int unsigned LINE_W = 10;
  localparam int unsigned POS_W  = 9;
  localparam int unsigned NV     = 32;
  localparam int unsigned VW     = 31;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              tick_en = 1'b0;
  logic              sys_ccir = 1'b0;
  logic              clamp_cont = 1'b1;
  logic              field_odd = 1'b1;
  logic [LINE_W-1:0] line_idx = '0;
  logic              half_sel = 1'b0;
  logic [POS_W-1:0]  hpos = '0;
  logic              csync_n, cblank, hblank, clamp;

  int n_chk = 0;
  int n_bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  csync_gen_top #(
    .LINE_W (LINE_W), .POS_W (POS_W),
    .HALF_EIA (40), .HALF_CCIR (48),
    .EQ_EIA (3),    .EQ_CCIR (4),
    .HS_EIA (8),    .HS_CCIR (9),
    .SERR_EIA (6),  .SERR_CCIR (7),
    .CB_EIA (20),   .CB_CCIR (22),
    .HB_EIA (16),   .HB_CCIR (18),
    .VB_EIA (20),   .VB_CCIR (25),
    .CLAMP_START (10), .CLAMP_W (4)
  ) i_csync_gen_top (
    .clk, .rst_n, .tick_en, .sys_ccir, .clamp_cont, .field_odd,
    .line_idx, .half_sel, .hpos, .csync_n, .cblank, .hblank, .clamp
  );

  // {req, ccir, cont, odd, line, half, pos, {csync_n, cblank, hblank, clamp}}
  localparam logic [VW-1:0] VEC [NV] = '{
    {4'd3,  1'b0,1'b1,1'b1,10'd100,1'b0,9'd0,  4'b0110}, // R3 sync start
    {4'd3,  1'b0,1'b1,1'b1,10'd100,1'b0,9'd7,  4'b0110}, // R3 last low tick
    {4'd3,  1'b0,1'b1,1'b1,10'd100,1'b0,9'd8,  4'b1110}, // R3 sync end
    {4'd9,  1'b0,1'b1,1'b1,10'd100,1'b0,9'd11, 4'b1111}, // R9 clamp window
    {4'd8,  1'b0,1'b1,1'b1,10'd100,1'b0,9'd16, 4'b1100}, // R8 hblank end
    {4'd7,  1'b0,1'b1,1'b1,10'd100,1'b0,9'd20, 4'b1000}, // R7 cblank end
    {4'd3,  1'b0,1'b1,1'b1,10'd100,1'b1,9'd0,  4'b1000}, // R3 second half high
    {4'd4,  1'b0,1'b1,1'b1,10'd0,  1'b0,9'd2,  4'b0110}, // R4 eq low
    {4'd4,  1'b0,1'b1,1'b1,10'd0,  1'b0,9'd3,  4'b1110}, // R4 eq end
    {4'd4,  1'b0,1'b1,1'b1,10'd1,  1'b1,9'd2,  4'b0100}, // R4 eq second half
    {4'd5,  1'b0,1'b1,1'b1,10'd3,  1'b0,9'd33, 4'b0100}, // R5 serr low
    {4'd5,  1'b0,1'b1,1'b1,10'd3,  1'b0,9'd34, 4'b1100}, // R5 serr rise
    {4'd5,  1'b0,1'b1,1'b1,10'd5,  1'b1,9'd20, 4'b0100}, // R5 last serr half
    {4'd9,  1'b0,1'b1,1'b1,10'd6,  1'b0,9'd10, 4'b1111}, // R9 clamp in vblank
    {4'd10, 1'b0,1'b0,1'b1,10'd6,  1'b0,9'd10, 4'b1110}, // R10 clamp gated
    {4'd4,  1'b0,1'b1,1'b1,10'd9,  1'b0,9'd5,  4'b0110}, // R4 interval over
    {4'd4,  1'b0,1'b1,1'b1,10'd8,  1'b1,9'd2,  4'b0100}, // R4 last eq half
    {4'd6,  1'b0,1'b1,1'b0,10'd0,  1'b0,9'd5,  4'b0110}, // R6 even idx0 normal
    {4'd6,  1'b0,1'b1,1'b0,10'd3,  1'b0,9'd33, 4'b1100}, // R6 even still eq
    {4'd6,  1'b0,1'b1,1'b0,10'd3,  1'b1,9'd33, 4'b0100}, // R6 even serr
    {4'd6,  1'b0,1'b1,1'b0,10'd9,  1'b0,9'd5,  4'b1110}, // R6 even post eq
    {4'd10, 1'b0,1'b0,1'b1,10'd19, 1'b0,9'd11, 4'b1110}, // R10 last vb line
    {4'd10, 1'b0,1'b0,1'b1,10'd20, 1'b0,9'd11, 4'b1111}, // R10 clamp back
    {4'd7,  1'b0,1'b0,1'b1,10'd20, 1'b0,9'd25, 4'b1000}, // R7 first active
    {4'd7,  1'b0,1'b0,1'b1,10'd19, 1'b0,9'd25, 4'b1100}, // R7 last blanked
    {4'd11, 1'b1,1'b1,1'b1,10'd22, 1'b0,9'd25, 4'b1100}, // R11 ccir vb 25
    {4'd11, 1'b1,1'b1,1'b1,10'd25, 1'b0,9'd22, 4'b1000}, // R11 ccir cb end
    {4'd11, 1'b1,1'b1,1'b1,10'd100,1'b0,9'd8,  4'b0110}, // R11 ccir hs
    {4'd11, 1'b1,1'b1,1'b1,10'd100,1'b0,9'd18, 4'b1100}, // R11 ccir hb end
    {4'd11, 1'b1,1'b1,1'b1,10'd3,  1'b0,9'd40, 4'b0100}, // R11 ccir serr
    {4'd11, 1'b1,1'b1,1'b1,10'd3,  1'b0,9'd41, 4'b1100}, // R11 ccir serr rise
    {4'd11, 1'b1,1'b1,1'b1,10'd0,  1'b0,9'd3,  4'b0110}  // R11 ccir eq
  };

  task automatic drive(input logic [VW-1:0] v, input logic tick);
    {sys_ccir, clamp_cont, field_odd, line_idx, half_sel, hpos} = v[VW-5:4];
    tick_en = tick;
  endtask

  task automatic check(input int req, input int idx, input logic [3:0] exp);
    logic [3:0] got;
    got = {csync_n, cblank, hblank, clamp};
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL R%0d step %0d: got %b expected %b", req, idx, got, exp);
    end
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    n_bad++;
    $display("FAIL watchdog: got hang expected completion");
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    // R1: reset state
    repeat (3) @(negedge clk);
    check(1, -1, 4'b1000);
    rst_n = 1'b1;
    @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      drive(VEC[i], 1'b1);
      @(posedge clk);
      @(negedge clk);
      tick_en = 1'b0;
      check(int'(VEC[i][VW-1:VW-4]), i, VEC[i][3:0]);
    end

    // R2: inputs change without a tick, outputs hold
    drive(VEC[0], 1'b1);
    @(posedge clk); @(negedge clk);
    drive(VEC[6], 1'b0);
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(2, 100, 4'b0110);
    // R2: the next tick picks the new inputs up one clock later
    tick_en = 1'b1;
    @(posedge clk); @(negedge clk);
    tick_en = 1'b0;
    check(2, 101, 4'b1000);

    // R1: reset in mid-run forces the idle state
    drive(VEC[3], 1'b1);
    @(posedge clk); @(negedge clk);
    check(9, 102, 4'b1111);
    rst_n = 1'b0;
    @(negedge clk);
    check(1, 103, 4'b1000);
    rst_n = 1'b1;
    tick_en = 1'b0;
    @(negedge clk);
    check(1, 104, 4'b1000);

    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule